// File: doc/BRIEF.md
# Atomic Swap Bus Controller

This block carries out an indivisible exchange between one register and one memory location. A single start pulse hands it a target address, a byte-or-word select, the value to be stored and the index of the register that receives the old memory contents. The block then runs a fixed four-cycle sequence. It presents the address, reads the location, writes the new value to the same location, and finally issues a register-file write with the data it read.

While the read and the write are on the bus, a lock output stays high so that an arbiter keeps the pair together. An abort input is sampled in each of the two bus cycles. When it is sampled high, the register file is left untouched and a one-cycle abort flag is raised. An abort during the read also cancels the write. For byte exchanges the stored byte is copied onto every lane of the write bus, and the loaded byte is taken from the lane chosen by the low address bits and zero-extended.

Top module: `swap_bus_ctrl`

## Requirements
- R1: After reset the block is idle: busy, memory request, lock, register write enable and abort flag are all low.
- R2: A start pulse seen while idle begins the sequence. In the first cycle the address is presented with busy high and no memory request. In the second cycle there is a read request (bus_nrw_o low). In the third cycle there is a write request (bus_nrw_o high) at the same address. The fourth cycle is a register-file write, after which the block is idle again.
- R3: Lock is high in the read cycle and in the write cycle, and low in every other cycle.
- R4: In a word write cycle, bus_wdata_o equals the source value captured with the start pulse.
- R5: In the fourth cycle, rf_idx_o is the destination index captured at start. rf_wdata_o is the read data sampled at the end of the read cycle; later changes on the read bus are not taken.
- R6: For a byte swap, bus_nbw_o is low during both bus cycles. The write data is source bits 7:0 repeated in all four byte lanes. The loaded value is lane k (bits 8k+7:8k, k = address bits 1:0), zero-extended to 32 bits.
- R7: For a word swap, bus_nbw_o is high during both bus cycles, and the full 32-bit read word is loaded.
- R8: If abort is high in the read cycle, no write cycle follows. Lock and request are low in the next cycle, the abort flag is high for exactly that one cycle, and no register write happens.
- R9: If abort is high in the write cycle, no register write happens. In the next cycle the block is idle with the abort flag high for one cycle.
- R10: A start pulse while busy is ignored. The address in use does not change, and no new sequence begins after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a swap |
| addr_i | input | ADDR_W | Swap address |
| byte_i | input | 1 | 1 = byte swap, 0 = word swap |
| src_data_i | input | 32 | Value to store to memory |
| dst_idx_i | input | IDX_W | Register receiving the old memory value |
| abort_i | input | 1 | Memory abort, sampled in the read and write cycles |
| rd_data_i | input | 32 | Memory read data |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_req_o | output | 1 | Memory transfer active |
| bus_nrw_o | output | 1 | 0 = read, 1 = write |
| bus_nbw_o | output | 1 | 0 = byte, 1 = word |
| bus_lock_o | output | 1 | Keep the bus transfers together |
| bus_wdata_o | output | 32 | Write data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_idx_o | output | IDX_W | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| busy_o | output | 1 | Sequence in progress |
| abort_o | output | 1 | One-cycle abort flag |

## Verification
Counting from the clock edge that samples start, the address cycle is visible after one edge. The read follows after two edges, the write after three and the register write after four. An abort flag appears one edge after the bus cycle in which abort was sampled. The driver pushes one expected record per cycle into a queue in that order. The monitor pops one record every cycle at a fixed delay after the falling edge, so each result is compared in the exact cycle it is due. Read data is changed after the read cycle, so a late capture would not match.

// File: rtl/swap_pkg.sv
package swap_pkg;
  typedef enum logic [2:0] {
    SW_IDLE   = 3'd0,
    SW_ADDR   = 3'd1,
    SW_READ   = 3'd2,
    SW_WRITE  = 3'd3,
    SW_UPDATE = 3'd4
  } swap_state_e;
endpackage

// File: rtl/swap_seq.sv
module swap_seq
  import swap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        abort_i,
  output swap_state_e state_o,
  output logic        load_en_o,
  output logic        capture_en_o,
  output logic        abort_flag_o
);
  swap_state_e state_q, state_n;
  logic        abort_q, abort_n;

  always_comb begin
    state_n = state_q;
    abort_n = 1'b0;
    unique case (state_q)
      SW_IDLE:   if (start_i) state_n = SW_ADDR;
      SW_ADDR:   state_n = SW_READ;
      SW_READ: begin
        if (abort_i) begin
          state_n = SW_IDLE;
          abort_n = 1'b1;
        end else begin
          state_n = SW_WRITE;
        end
      end
      SW_WRITE: begin
        if (abort_i) begin
          state_n = SW_IDLE;
          abort_n = 1'b1;
        end else begin
          state_n = SW_UPDATE;
        end
      end
      SW_UPDATE: state_n = SW_IDLE;
      default:   state_n = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_n;
      abort_q <= abort_n;
    end
  end

  assign state_o      = state_q;
  assign load_en_o    = (state_q == SW_IDLE) && start_i;
  assign capture_en_o = (state_q == SW_READ);
  assign abort_flag_o = abort_q;
endmodule

// File: rtl/swap_lane.sv
module swap_lane #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              byte_i,
  input  logic [SEL_W-1:0]  lane_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] rd_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] load_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wdata_o[8*g +: 8] = byte_i ? src_i[7:0] : src_i[8*g +: 8];
  end

  always_comb begin
    load_o = '0;
    if (byte_i) begin
      for (int k = 0; k < LANES; k++) begin
        if (lane_i == SEL_W'(k)) load_o[7:0] = rd_i[8*k +: 8];
      end
    end else begin
      load_o = rd_i;
    end
  end
endmodule

// File: rtl/swap_bus_ctrl.sv
module swap_bus_ctrl
  import swap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  localparam int SEL_W = (DATA_W / 8 > 1) ? $clog2(DATA_W / 8) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_req_o,
  output logic              bus_nrw_o,
  output logic              bus_nbw_o,
  output logic              bus_lock_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_idx_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              busy_o,
  output logic              abort_o
);
  swap_state_e       state;
  logic              load_en, capture_en;
  logic [ADDR_W-1:0] addr_q;
  logic              byte_q;
  logic [DATA_W-1:0] src_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] load_val, load_q;

  swap_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .abort_i      (abort_i),
    .state_o      (state),
    .load_en_o    (load_en),
    .capture_en_o (capture_en),
    .abort_flag_o (abort_o)
  );

  swap_lane #(.DATA_W(DATA_W)) u_lane (
    .byte_i  (byte_q),
    .lane_i  (addr_q[SEL_W-1:0]),
    .src_i   (src_q),
    .rd_i    (rd_data_i),
    .wdata_o (bus_wdata_o),
    .load_o  (load_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      byte_q <= 1'b0;
      src_q  <= '0;
      idx_q  <= '0;
    end else if (load_en) begin
      addr_q <= addr_i;
      byte_q <= byte_i;
      src_q  <= src_data_i;
      idx_q  <= dst_idx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
    end else if (capture_en) begin
      load_q <= load_val;
    end
  end

  assign bus_addr_o = addr_q;
  assign bus_req_o  = (state == SW_READ) || (state == SW_WRITE);
  assign bus_lock_o = bus_req_o;
  assign bus_nrw_o  = (state == SW_WRITE);
  assign bus_nbw_o  = !byte_q;
  assign rf_we_o    = (state == SW_UPDATE);
  assign rf_idx_o   = idx_q;
  assign rf_wdata_o = load_q;
  assign busy_o     = (state != SW_IDLE);
endmodule

// File: rtl/swap_bus_ctrl_chk.sv
module swap_bus_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort_i,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_req_o,
  input logic              bus_nrw_o,
  input logic              bus_nbw_o,
  input logic              bus_lock_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              rf_we_o,
  input logic              busy_o,
  input logic              abort_o
);
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_nrw_o && !abort_i) |=> (bus_req_o && bus_nrw_o && bus_lock_o)); // R2
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_nrw_o) |=> !bus_lock_o); // R3
  AST_LOCK_STARTS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock_o) |-> !bus_nrw_o); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock_o && $past(bus_lock_o)) |-> $stable(bus_addr_o)); // R2
  AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock_o && $past(bus_lock_o)) |-> $stable(bus_nbw_o)); // R6
  AST_BYTE_REPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_nrw_o && !bus_nbw_o) |->
      (bus_wdata_o[31:8] == {3{bus_wdata_o[7:0]}})); // R6
  AST_RF_AFTER_CLEAN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> $past(bus_req_o && bus_nrw_o && !abort_i)); // R9
  AST_READ_ABORT_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_nrw_o && abort_i) |=> (!bus_req_o && !rf_we_o && abort_o)); // R8
  AST_WRITE_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_nrw_o && abort_i) |=> (!busy_o && !rf_we_o && abort_o)); // R9
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o); // R8
endmodule

bind swap_bus_ctrl swap_bus_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .abort_i     (abort_i),
  .bus_addr_o  (bus_addr_o),
  .bus_req_o   (bus_req_o),
  .bus_nrw_o   (bus_nrw_o),
  .bus_nbw_o   (bus_nbw_o),
  .bus_lock_o  (bus_lock_o),
  .bus_wdata_o (bus_wdata_o),
  .rf_we_o     (rf_we_o),
  .busy_o      (busy_o),
  .abort_o     (abort_o)
);

// File: tb/swap_bus_ctrl_test.sv
`timescale 1ns/1ps
module swap_bus_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        byte_i = 1'b0;
  logic [31:0] src_data_i = '0;
  logic [3:0]  dst_idx_i = '0;
  logic        abort_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic [31:0] bus_addr_o, bus_wdata_o, rf_wdata_o;
  logic        bus_req_o, bus_nrw_o, bus_nbw_o, bus_lock_o, rf_we_o, busy_o, abort_o;
  logic [3:0]  rf_idx_o;

  swap_bus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .byte_i(byte_i),
    .src_data_i(src_data_i), .dst_idx_i(dst_idx_i), .abort_i(abort_i), .rd_data_i(rd_data_i),
    .bus_addr_o(bus_addr_o), .bus_req_o(bus_req_o), .bus_nrw_o(bus_nrw_o),
    .bus_nbw_o(bus_nbw_o), .bus_lock_o(bus_lock_o), .bus_wdata_o(bus_wdata_o),
    .rf_we_o(rf_we_o), .rf_idx_o(rf_idx_o), .rf_wdata_o(rf_wdata_o),
    .busy_o(busy_o), .abort_o(abort_o)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit          busy, req, nrw, nbw, lock, we, abt;
    bit          chk_addr, chk_nbw, chk_wdata, chk_rf;
    logic [31:0] addr, wdata, rfdata;
    logic [3:0]  idx;
    string       rq;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Monitor: one expected record per cycle, compared 2 ns after the falling edge.
  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      bit ok;
      e = exp_q.pop_front();
      ok = (busy_o == e.busy) && (bus_req_o == e.req) && (bus_nrw_o == e.nrw) &&
           (bus_lock_o == e.lock) && (rf_we_o == e.we) && (abort_o == e.abt);
      check(ok, e.rq, "ctrl{busy,req,nrw,lock,we,abt}",
            {26'd0, busy_o, bus_req_o, bus_nrw_o, bus_lock_o, rf_we_o, abort_o},
            {26'd0, e.busy, e.req, e.nrw, e.lock, e.we, e.abt});
      if (e.chk_addr) check(bus_addr_o == e.addr, e.rq, "addr", bus_addr_o, e.addr);
      if (e.chk_nbw)  check(bus_nbw_o == e.nbw, e.rq, "nbw", {31'd0, bus_nbw_o}, {31'd0, e.nbw});
      if (e.chk_wdata) check(bus_wdata_o == e.wdata, e.rq, "wdata", bus_wdata_o, e.wdata);
      if (e.chk_rf) begin
        check(rf_wdata_o == e.rfdata, e.rq, "rf_wdata", rf_wdata_o, e.rfdata);
        check(rf_idx_o == e.idx, e.rq, "rf_idx", {28'd0, rf_idx_o}, {28'd0, e.idx});
      end
    end
  end

  function automatic exp_t blank(input string rq);
    exp_t e;
    e = '{busy:0, req:0, nrw:0, nbw:0, lock:0, we:0, abt:0,
          chk_addr:0, chk_nbw:0, chk_wdata:0, chk_rf:0,
          addr:'0, wdata:'0, rfdata:'0, idx:'0, rq:rq};
    return e;
  endfunction

  // Driver: abort_at 0 = none, 2 = read cycle, 3 = write cycle.
  task automatic do_swap(input logic [31:0] a, input bit by, input logic [31:0] src,
                         input logic [3:0] idx, input logic [31:0] rd,
                         input int abort_at, input bit poke_busy, input string rq);
    exp_t e;
    logic [31:0] wexp, lexp;
    wexp = by ? {4{src[7:0]}} : src;
    lexp = by ? {24'd0, rd[8*a[1:0] +: 8]} : rd;
    @(negedge clk);
    start_i = 1'b1; addr_i = a; byte_i = by; src_data_i = src; dst_idx_i = idx;
    @(negedge clk);                                    // cycle 1: address
    if (poke_busy) begin
      addr_i = ~a; byte_i = ~by; src_data_i = ~src; dst_idx_i = ~idx;
    end else start_i = 1'b0;
    e = blank({rq, " R2 addr cycle"}); e.busy = 1; e.chk_addr = 1; e.addr = a;
    exp_q.push_back(e);
    @(negedge clk);                                    // cycle 2: read
    rd_data_i = rd; abort_i = (abort_at == 2);
    e = blank({rq, " R2 R3 read"}); e.busy = 1; e.req = 1; e.lock = 1;
    e.chk_addr = 1; e.addr = a; e.chk_nbw = 1; e.nbw = !by;
    exp_q.push_back(e);
    @(negedge clk);
    abort_i = 1'b0; rd_data_i = ~rd;
    if (abort_at == 2) begin
      start_i = 1'b0;
      e = blank({rq, " R8 read abort"}); e.abt = 1;
      exp_q.push_back(e);
    end else begin                                     // cycle 3: write
      abort_i = (abort_at == 3);
      e = blank({rq, " R3 R4 R6 write"}); e.busy = 1; e.req = 1; e.nrw = 1; e.lock = 1;
      e.chk_addr = 1; e.addr = a; e.chk_nbw = 1; e.nbw = !by; e.chk_wdata = 1; e.wdata = wexp;
      exp_q.push_back(e);
      @(negedge clk);
      abort_i = 1'b0; start_i = 1'b0;
      if (abort_at == 3) begin
        e = blank({rq, " R9 write abort"}); e.abt = 1;
      end else begin                                   // cycle 4: register write
        e = blank({rq, " R5 R7 update"}); e.busy = 1; e.we = 1;
        e.chk_rf = 1; e.rfdata = lexp; e.idx = idx;
      end
      exp_q.push_back(e);
    end
    @(negedge clk);
    e = blank({rq, " R10 idle after"});
    exp_q.push_back(e);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(!busy_o && !bus_req_o && !bus_lock_o && !rf_we_o && !abort_o, "R1", "reset outputs",
          {27'd0, busy_o, bus_req_o, bus_lock_o, rf_we_o, abort_o}, 32'd0);
    rst_n = 1'b1;
    do_swap(32'h0000_1000, 1'b0, 32'hCAFE_F00D, 4'd3, 32'h1234_5678, 0, 1'b0, "word");
    do_swap(32'h0000_2001, 1'b1, 32'h0000_00A5, 4'd7, 32'h4433_2211, 0, 1'b0, "byte lane1 R6");
    do_swap(32'h0000_2003, 1'b1, 32'h1111_225A, 4'd9, 32'h8877_6655, 0, 1'b0, "byte lane3 R6");
    do_swap(32'h0000_2000, 1'b1, 32'h0000_00FF, 4'd1, 32'hDEAD_BE80, 0, 1'b0, "byte lane0 R6");
    do_swap(32'h0000_3000, 1'b0, 32'h0BAD_0BAD, 4'd5, 32'h5555_AAAA, 2, 1'b0, "abort read");
    do_swap(32'h0000_4000, 1'b0, 32'h7777_8888, 4'd6, 32'h9999_0000, 3, 1'b0, "abort write");
    do_swap(32'h0000_5004, 1'b0, 32'hFEED_FACE, 4'd15, 32'h0F0F_F0F0, 0, 1'b1, "busy start R10");
    do_swap(32'hFFFF_FFFE, 1'b1, 32'hABCD_EF12, 4'd0, 32'hC3B2_A190, 0, 1'b0, "byte lane2 R6");
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule